// File: doc/BRIEF.md
# Double-Word Shift and Rotate Unit

This block carries out the six shift and rotate operations of an extended arithmetic group on a 32-bit operand. The operand is made from two 16-bit accumulators: B supplies the upper half and A the lower half. A caller presents an instruction word, the two register values and a start strobe. One clock edge later the block returns the new A and B values, an overflow write strobe with its value, and a one-cycle done pulse.

The instruction word carries three fields. Bits 15-8 select the direction group, bits 7-4 select the operation kind, and bits 3-0 give the shift distance. Arithmetic, logical and rotate variants exist in each direction. Only the arithmetic ops touch the overflow flag. Undefined codes in the right-going group are reported on a separate strobe and change nothing. Any other instruction word is not handled by this block and is ignored.

Top module: `dw_shift_unit`

## Requirements
- R1: The shift distance is instruction bits 3-0. A value of 1 to 15 is used as given, and a value of 0 means a distance of 16.
- R2: Bits 15-8 equal to octal 200 select the left-going ops and octal 202 selects the right-going ops. Bits 7-4 equal to 1 select the arithmetic op, 2 the logical op and 4 the rotate op.
- R3: The arithmetic left shift keeps bit 31 of {B,A}. Bits 30-0 move left, bits pushed past bit 30 are lost, and zeros enter at bit 0.
- R4: The arithmetic left shift writes overflow (ovf_wr_o=1). ovf_o=1 when any lost bit differs from the original bit 31, and ovf_o=0 otherwise.
- R5: The arithmetic right shift fills the vacated upper bits with copies of bit 31, and it writes overflow as 0.
- R6: The logical shifts fill with zeros, and the rotates feed the bits leaving one end back in at the other end. None of these four ops writes overflow: ovf_wr_o=0 and ovf_o keeps its value.
- R7: On the clock edge after a start with a defined op, b_o holds result bits 31-16, a_o holds result bits 15-0, and done_o is 1 for that one cycle.
- R8: A start with bits 15-8 equal to octal 202 and bits 7-4 not equal to 1, 2 or 4 raises undef_o for one cycle. In that cycle done_o=0, ovf_wr_o=0, a_o and b_o equal the presented A and B, and ovf_o keeps its value.
- R9: A start with any other instruction word produces no done_o and no undef_o, and a_o, b_o and ovf_o keep their values.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| instr_i | input | 16 | Instruction word |
| a_i | input | 16 | Lower operand word (A) |
| b_i | input | 16 | Upper operand word (B) |
| a_o | output | 16 | New lower word |
| b_o | output | 16 | New upper word |
| ovf_o | output | 1 | Overflow value |
| ovf_wr_o | output | 1 | Overflow write strobe |
| done_o | output | 1 | Completion pulse |
| undef_o | output | 1 | Undefined-code pulse |

## Verification
Every output register loads on the edge that follows start, so a decode or fill fault shows up at a_o, b_o or the overflow pair on the very next cycle. Faults to look for include a count of 0 read as 0 instead of 16, a sign bit that is shifted out on the arithmetic left shift, a wrong fill on the right shift, or a wrong lost-bit window in the overflow test. A stale strobe would show as done_o or undef_o held high for more than one cycle, or raised for an instruction word that should be ignored. Overflow that is written when it should only be held shows up later: the first arithmetic op then reports a value that depends on history.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_ASL, OP_LSL, OP_RRL, OP_ASR, OP_LSR, OP_RRR
  } shift_op_e;

  localparam int INSTR_W = 16;
  localparam int GRP_LSB = 8;
  localparam int SUB_LSB = 4;
  localparam logic [7:0] GRP_LEFT  = 8'o200;
  localparam logic [7:0] GRP_RIGHT = 8'o202;
  localparam logic [3:0] SUB_ARITH = 4'd1;
  localparam logic [3:0] SUB_LOGIC = 4'd2;
  localparam logic [3:0] SUB_ROT   = 4'd4;
endpackage

// File: rtl/dws_decode.sv
module dws_decode
  import dws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [INSTR_W-1:0] instr_i,
  output shift_op_e          op_o,
  output logic [CNT_W:0]     cnt_o,
  output logic               undef_o
);
  logic [7:0]       grp;
  logic [3:0]       sub;
  logic [CNT_W-1:0] fld;

  assign grp = instr_i[GRP_LSB +: 8];
  assign sub = instr_i[SUB_LSB +: 4];
  assign fld = instr_i[CNT_W-1:0];

  // zero field encodes the full half-word distance
  assign cnt_o = (fld == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, fld};

  always_comb begin
    op_o    = OP_NONE;
    undef_o = 1'b0;
    if (grp == GRP_LEFT) begin
      unique case (sub)
        SUB_ARITH: op_o = OP_ASL;
        SUB_LOGIC: op_o = OP_LSL;
        SUB_ROT:   op_o = OP_RRL;
        default:   op_o = OP_NONE;
      endcase
    end else if (grp == GRP_RIGHT) begin
      unique case (sub)
        SUB_ARITH: op_o = OP_ASR;
        SUB_LOGIC: op_o = OP_LSR;
        SUB_ROT:   op_o = OP_RRR;
        default:   undef_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dws_barrel.sv
module dws_barrel
  import dws_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4
) (
  input  shift_op_e           op_i,
  input  logic [2*WORD_W-1:0] x_i,
  input  logic [CNT_W:0]      cnt_i,
  output logic [2*WORD_W-1:0] y_o,
  output logic                ovf_o,
  output logic                ovf_wr_o
);
  localparam int DW = 2 * WORD_W;

  logic [DW-1:0]   shl, shr, sar;
  logic [2*DW-1:0] dbl_l, dbl_r;
  logic            lost_diff;

  assign shl   = x_i << cnt_i;
  assign shr   = x_i >> cnt_i;
  assign sar   = DW'($signed(x_i) >>> cnt_i);
  assign dbl_l = {x_i, x_i} << cnt_i;
  assign dbl_r = {x_i, x_i} >> cnt_i;

  // bits at positions DW-1-cnt .. DW-2 are pushed past the sign
  always_comb begin
    lost_diff = 1'b0;
    for (int i = 0; i < DW-1; i++) begin
      if ((i + int'(cnt_i) >= DW-1) && (x_i[i] != x_i[DW-1])) lost_diff = 1'b1;
    end
  end

  always_comb begin
    y_o      = x_i;
    ovf_o    = 1'b0;
    ovf_wr_o = 1'b0;
    unique case (op_i)
      OP_ASL: begin
        y_o      = {x_i[DW-1], shl[DW-2:0]};
        ovf_o    = lost_diff;
        ovf_wr_o = 1'b1;
      end
      OP_LSL: y_o = shl;
      OP_RRL: y_o = dbl_l[2*DW-1:DW];
      OP_ASR: begin
        y_o      = sar;
        ovf_wr_o = 1'b1;
      end
      OP_LSR: y_o = shr;
      OP_RRR: y_o = dbl_r[DW-1:0];
      default: y_o = x_i;
    endcase
  end
endmodule

// File: rtl/dw_shift_unit.sv
module dw_shift_unit
  import dws_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       instr_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic              ovf_o,
  output logic              ovf_wr_o,
  output logic              done_o,
  output logic              undef_o
);
  localparam int DW = 2 * WORD_W;

  shift_op_e     dec_op;
  logic [CNT_W:0] dec_cnt;
  logic          dec_undef;
  logic [DW-1:0] res;
  logic          res_ovf, res_ovf_wr;

  dws_decode #(.CNT_W(CNT_W)) u_dec (
    .instr_i (instr_i),
    .op_o    (dec_op),
    .cnt_o   (dec_cnt),
    .undef_o (dec_undef)
  );

  dws_barrel #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_bsh (
    .op_i     (dec_op),
    .x_i      ({b_i, a_i}),
    .cnt_i    (dec_cnt),
    .y_o      (res),
    .ovf_o    (res_ovf),
    .ovf_wr_o (res_ovf_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o      <= '0;
      b_o      <= '0;
      ovf_o    <= 1'b0;
      ovf_wr_o <= 1'b0;
      done_o   <= 1'b0;
      undef_o  <= 1'b0;
    end else begin
      ovf_wr_o <= 1'b0;
      done_o   <= 1'b0;
      undef_o  <= 1'b0;
      if (start_i && dec_op != OP_NONE) begin
        {b_o, a_o} <= res;
        done_o     <= 1'b1;
        ovf_wr_o   <= res_ovf_wr;
        if (res_ovf_wr) ovf_o <= res_ovf;
      end else if (start_i && dec_undef) begin
        a_o     <= a_i;
        b_o     <= b_i;
        undef_o <= 1'b1;
      end
    end
  end

  // R8: undefined codes never complete and never write overflow
  assert_undef_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (!done_o && !ovf_wr_o));
  assert_undef_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (a_o == $past(a_i) && b_o == $past(b_i) && $stable(ovf_o)));
  // R3: arithmetic left shift keeps the sign
  assert_asl_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec_op == OP_ASL) |=> (b_o[WORD_W-1] == $past(b_i[WORD_W-1])));
  // R5: arithmetic right shift clears overflow
  assert_asr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec_op == OP_ASR) |=> (ovf_wr_o && !ovf_o));
  // R6: rotates keep the population count
  assert_rot_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (dec_op == OP_RRL || dec_op == OP_RRR)) |=>
      ($countones({b_o, a_o}) == $countones($past({b_i, a_i}))));
  // R6: logical and rotate ops leave overflow alone
  assert_no_ovf_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (dec_op == OP_LSL || dec_op == OP_LSR || dec_op == OP_RRL || dec_op == OP_RRR))
      |=> (!ovf_wr_o && $stable(ovf_o)));
  // R9: words outside both groups are ignored
  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec_op == OP_NONE && !dec_undef) |=>
      (!done_o && !undef_o && $stable(a_o) && $stable(b_o)));
endmodule

// File: tb/dw_shift_unit_test.sv
`timescale 1ns/1ps
module dw_shift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic        ovf, ovf_wr, done, undef;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference state
  logic [15:0] m_a = '0, m_b = '0;
  logic        m_ovf = 0, m_ovf_wr = 0, m_done = 0, m_undef = 0;

  always #2.5 clk = ~clk;

  dw_shift_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .a_i(a_in), .b_i(b_in), .a_o(a_out), .b_o(b_out), .ovf_o(ovf),
    .ovf_wr_o(ovf_wr), .done_o(done), .undef_o(undef)
  );

  function automatic string req_of(logic [15:0] ins);
    logic [7:0] g; logic [3:0] s;
    g = ins[15:8]; s = ins[7:4];
    if (g != 8'o200 && g != 8'o202) return "R9";
    if (g == 8'o202 && !(s == 1 || s == 2 || s == 4)) return "R8";
    if (g == 8'o200 && !(s == 1 || s == 2 || s == 4)) return "R9";
    if (s == 1 && g == 8'o200) return "R3/R4";
    if (s == 1) return "R5";
    return "R6";
  endfunction

  // behavioural model: one bit position per step
  task automatic model(logic st, logic [15:0] ins, logic [15:0] a, logic [15:0] b);
    logic [31:0] x; int n; logic [7:0] g; logic [3:0] s; logic lost;
    m_done = 0; m_undef = 0; m_ovf_wr = 0;
    if (!st) return;
    g = ins[15:8]; s = ins[7:4];
    n = (ins[3:0] == 0) ? 16 : int'(ins[3:0]);   // R1
    x = {b, a};
    lost = 0;
    if (g == 8'o200 && (s == 1 || s == 2 || s == 4)) begin   // R2
      for (int k = 0; k < n; k++) begin
        if (s == 1) begin
          if (x[30] != x[31]) lost = 1;
          x = {x[31], x[29:0], 1'b0};
        end else if (s == 2) x = {x[30:0], 1'b0};
        else x = {x[30:0], x[31]};
      end
      if (s == 1) begin m_ovf = lost; m_ovf_wr = 1; end
      {m_b, m_a} = x; m_done = 1;
    end else if (g == 8'o202 && (s == 1 || s == 2 || s == 4)) begin
      for (int k = 0; k < n; k++) begin
        if (s == 1) x = {x[31], x[31:1]};
        else if (s == 2) x = {1'b0, x[31:1]};
        else x = {x[0], x[31:1]};
      end
      if (s == 1) begin m_ovf = 0; m_ovf_wr = 1; end
      {m_b, m_a} = x; m_done = 1;
    end else if (g == 8'o202) begin
      m_a = a; m_b = b; m_undef = 1;
    end
  endtask

  task automatic compare(string req);
    compared++;
    if ({a_out, b_out, ovf, ovf_wr, done, undef} !==
        {m_a, m_b, m_ovf, m_ovf_wr, m_done, m_undef}) begin
      mismatched++;
      $display("FAIL %s: got a=%h b=%h ovf=%b wr=%b done=%b undef=%b, expected a=%h b=%h ovf=%b wr=%b done=%b undef=%b",
               req, a_out, b_out, ovf, ovf_wr, done, undef,
               m_a, m_b, m_ovf, m_ovf_wr, m_done, m_undef);
    end
  endtask

  // drive at negedge, registers load at posedge, compare at next negedge
  task automatic step(logic st, logic [15:0] ins, logic [15:0] a, logic [15:0] b);
    start = st; instr = ins; a_in = a; b_in = b;
    @(negedge clk);
    model(st, ins, a, b);
    compare(st ? {req_of(ins), " R7"} : "R7 idle");
  endtask

  function automatic logic [15:0] op(logic [7:0] g, logic [3:0] s, logic [3:0] c);
    return {g, s, c};
  endfunction

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10 after release");

    // R3/R4 arithmetic left
    step(1, op(8'o200, 1, 4'd3), 16'h0001, 16'h0F00);  // positive, no loss
    step(1, op(8'o200, 1, 4'd4), 16'h0000, 16'h0800);  // positive, 1 lost -> ovf
    step(1, op(8'o200, 1, 4'd2), 16'h1234, 16'hE000);  // negative, lost 1s -> no ovf
    step(1, op(8'o200, 1, 4'd3), 16'h0000, 16'h9000);  // negative, lost 0 -> ovf
    step(1, op(8'o200, 1, 4'd0), 16'hABCD, 16'h0000);  // R1 count 16, positive, lost bit 15 of A =1
    step(1, op(8'o200, 1, 4'd0), 16'h7FFF, 16'hFFFF);  // R1 count 16, negative
    // R5 arithmetic right
    step(1, op(8'o202, 1, 4'd4), 16'h5678, 16'h8000);
    step(1, op(8'o202, 1, 4'd0), 16'h5678, 16'h8000);
    step(1, op(8'o202, 1, 4'd1), 16'hFFFF, 16'h7FFF);
    // R6 logical and rotate, overflow must hold
    step(1, op(8'o200, 2, 4'd5), 16'hF00F, 16'h0FF0);
    step(1, op(8'o202, 2, 4'd0), 16'h1111, 16'hBEEF);
    step(1, op(8'o200, 4, 4'd1), 16'h0001, 16'h8000);
    step(1, op(8'o202, 4, 4'd0), 16'hCAFE, 16'hF00D);
    step(1, op(8'o202, 4, 4'd15), 16'h0001, 16'h0000);
    // R8 undefined codes
    step(1, op(8'o202, 0, 4'd1), 16'h1357, 16'h2468);
    step(1, op(8'o202, 3, 4'd1), 16'hAAAA, 16'h5555);
    step(1, op(8'o202, 15, 4'd0), 16'h0F0F, 16'hF0F0);
    // R9 ignored words
    step(1, op(8'o200, 8, 4'd0), 16'h1111, 16'h2222);
    step(1, op(8'o201, 1, 4'd1), 16'h3333, 16'h4444);
    step(1, op(8'o210, 4, 4'd2), 16'h5555, 16'h6666);
    step(1, op(8'o200, 3, 4'd0), 16'h7777, 16'h8888);
    step(0, op(8'o200, 1, 4'd1), 16'hFFFF, 16'h7FFF);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] g; logic [3:0] s;
      case ($urandom % 4)
        0: g = 8'o200; 1: g = 8'o202; 2: g = 8'o201; default: g = 8'($urandom);
      endcase
      s = ($urandom % 3 == 0) ? 4'($urandom) : 4'(1 << ($urandom % 3));
      step(1'($urandom % 5 != 0), op(g, s, 4'($urandom)), 16'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule